// File: doc/BRIEF.md
# Idle-Level I/O Read Redirection Unit

This unit sits on a core's I/O read path and inspects every read before it leaves for the system. Older operating systems ask for a deep idle state by reading one of two idle-level ports. When redirection is switched on, such a read is not sent out as an I/O cycle. The unit swallows it and emits an internal C-state request on a separate valid/ready channel. Every other read is forwarded untouched.

The idle-level ports sit at fixed offsets from a programmable base. Level two is at base+4 and maps to C3. Level three is at base+5 and maps to C6. A limit field names the highest level that may be trapped, and a level read above the limit goes out as a normal read. Each generated request carries a substate of zero and always sets the flag that lets an interrupt wake the core while interrupts are masked.

All three streams use valid/ready, and the rules for back-pressure are these:
- On the upstream read channel, the sender must hold the address steady while valid is high and ready is low.
- The unit holds a trapped read (ready low) until the C-state request has been accepted. In the cycle after that, it completes the read with zero data.
- A read that is forwarded takes its ready straight from the downstream I/O channel.
- The C-state request holds its payload steady until it is accepted.
- The configuration inputs must stay stable while a trapped read is in flight.

Top module: `idle_io_redirect`

## Requirements
- R1: With `cfg_en` low, `io_valid` equals `rd_valid`, `io_addr` equals `rd_addr`, `rd_ready` equals `io_ready`, and no C-state request or completion is produced.
- R2: With `cfg_en` high, a read at `cfg_base`+4 is the level-2 idle read and a read at `cfg_base`+5 is the level-3 idle read. The sums wrap modulo 2^AW. A read at any other address is forwarded as in R1.
- R3: A trapped level-2 read requests `cs_state` = 3 (C3). A trapped level-3 read requests `cs_state` = 6 (C6).
- R4: Level L is trapped only when L <= `cfg_limit`. With `cfg_limit` = 2 only level 2 is trapped, and with `cfg_limit` < 2 nothing is trapped. An untrapped level read is forwarded.
- R5: A trapped read never raises `io_valid`, from its arrival until its completion.
- R6: Every C-state request has `cs_sub` = 0.
- R7: Every C-state request has `cs_wake_masked` = 1.
- R8: `cs_valid` rises one cycle after a trapped read arrives. While `cs_ready` is low, `cs_valid` stays high with a stable `cs_state`, and `rd_ready` stays low.
- R9: In the cycle after `cs_valid && cs_ready`, `cpl_valid` and `rd_ready` are both high and `cpl_data` is zero, for exactly one cycle.
- R10: After reset, `cs_valid` and `cpl_valid` are low.
- R11: A forwarded read has `rd_ready` equal to `io_ready`, so downstream back-pressure reaches the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_valid | input | 1 | I/O read request valid from the core |
| rd_addr | input | AW | I/O read address |
| rd_ready | output | 1 | Read accepted (forwarded or completed) |
| cpl_valid | output | 1 | Completion of a trapped read |
| cpl_data | output | DW | Completion data, always zero |
| io_valid | output | 1 | Forwarded I/O read valid |
| io_addr | output | AW | Forwarded I/O read address |
| io_ready | input | 1 | Downstream I/O channel ready |
| cfg_en | input | 1 | Redirection enable |
| cfg_base | input | AW | Base of the idle-level port block |
| cfg_limit | input | LW | Highest idle level that is trapped |
| cs_valid | output | 1 | C-state request valid |
| cs_ready | input | 1 | C-state request accepted |
| cs_state | output | 4 | Requested C-state number |
| cs_sub | output | 4 | Requested substate, always zero |
| cs_wake_masked | output | 1 | Wake on interrupt even when masked |

## Verification
The bench builds the unit with its default parameters: a 16-bit address, a 32-bit completion, a 3-bit limit, and two trap levels starting at level 2. The 16-bit address lets a base of 0xFFFC place both idle ports across the wrap to 0x0000 and 0x0001. The 3-bit limit covers every limit case: below 2, exactly 2, and above 3. Holding the request channel stalled for several cycles shows the read being held and the payload staying stable.

// File: rtl/idle_redir_pkg.sv
package idle_redir_pkg;

  localparam int CS_W  = 4;
  localparam int SUB_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CPL  = 2'd2
  } redir_state_e;

  typedef struct packed {
    logic [CS_W-1:0]  state;
    logic [SUB_W-1:0] sub;
    logic             wake_masked;
  } cs_req_t;

  // Idle level to C-state number: level 2 -> C3, deeper levels -> C6.
  function automatic logic [CS_W-1:0] lvl_to_cstate(input int lvl);
    if (lvl == 2) return CS_W'(3);
    return CS_W'(6);
  endfunction

endpackage

// File: rtl/idle_lvl_decode.sv
module idle_lvl_decode
  import idle_redir_pkg::*;
#(
  parameter int AW        = 16,
  parameter int LW        = 3,
  parameter int LVL_FIRST = 2,
  parameter int LVL_COUNT = 2,
  parameter int LVL_OFS   = 2
) (
  input  logic            cfg_en,
  input  logic [AW-1:0]   cfg_base,
  input  logic [LW-1:0]   cfg_limit,
  input  logic [AW-1:0]   rd_addr,
  output logic            trap_hit,
  output logic [CS_W-1:0] trap_code
);

  logic [LVL_COUNT-1:0] lvl_hit;
  logic [CS_W-1:0]      lvl_code [LVL_COUNT];

  for (genvar i = 0; i < LVL_COUNT; i++) begin : g_lvl
    localparam int LVL = LVL_FIRST + i;
    logic [AW-1:0] slot;
    logic          allowed;
    assign slot        = cfg_base + AW'(LVL + LVL_OFS);
    assign allowed     = (LW'(LVL) <= cfg_limit);
    assign lvl_hit[i]  = cfg_en && allowed && (rd_addr == slot);
    assign lvl_code[i] = lvl_to_cstate(LVL);
  end

  always_comb begin
    trap_code = '0;
    for (int i = 0; i < LVL_COUNT; i++) begin
      if (lvl_hit[i]) trap_code = trap_code | lvl_code[i];
    end
  end

  assign trap_hit = |lvl_hit;

endmodule

// File: rtl/idle_req_fsm.sv
module idle_req_fsm
  import idle_redir_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic             trap_hit,
  input  logic [CS_W-1:0]  trap_code,
  input  logic             cs_ready,
  output logic             cs_valid,
  output logic [CS_W-1:0]  cs_state,
  output logic [SUB_W-1:0] cs_sub,
  output logic             cs_wake_masked,
  output logic             busy,
  output logic             trap_done
);

  redir_state_e st_q, st_d;
  cs_req_t      req_q, req_d;

  always_comb begin
    st_d  = st_q;
    req_d = req_q;
    unique case (st_q)
      ST_IDLE: if (rd_valid && trap_hit) begin
        st_d              = ST_REQ;
        req_d.state       = trap_code;
        req_d.sub         = '0;
        req_d.wake_masked = 1'b1;
      end
      ST_REQ:  if (cs_ready) st_d = ST_CPL;
      ST_CPL:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      req_q <= '0;
    end else begin
      st_q  <= st_d;
      req_q <= req_d;
    end
  end

  assign cs_valid       = (st_q == ST_REQ);
  assign cs_state       = req_q.state;
  assign cs_sub         = req_q.sub;
  assign cs_wake_masked = req_q.wake_masked;
  assign busy           = (st_q != ST_IDLE);
  assign trap_done      = (st_q == ST_CPL);

endmodule

// File: rtl/idle_pass_mux.sv
module idle_pass_mux #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          io_ready,
  input  logic          trap_hit,
  input  logic          busy,
  input  logic          trap_done,
  output logic          io_valid,
  output logic [AW-1:0] io_addr,
  output logic          rd_ready,
  output logic          cpl_valid,
  output logic [DW-1:0] cpl_data
);

  logic forward;

  assign forward   = !trap_hit && !busy;
  assign io_valid  = rd_valid && forward;
  assign io_addr   = rd_addr;
  assign rd_ready  = busy ? trap_done : (forward && io_ready);
  assign cpl_valid = trap_done;
  assign cpl_data  = '0;

endmodule

// File: rtl/idle_io_redirect.sv
module idle_io_redirect
  import idle_redir_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int LW        = 3,
  parameter int LVL_FIRST = 2,
  parameter int LVL_COUNT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [AW-1:0]    rd_addr,
  output logic             rd_ready,
  output logic             cpl_valid,
  output logic [DW-1:0]    cpl_data,
  output logic             io_valid,
  output logic [AW-1:0]    io_addr,
  input  logic             io_ready,
  input  logic             cfg_en,
  input  logic [AW-1:0]    cfg_base,
  input  logic [LW-1:0]    cfg_limit,
  output logic             cs_valid,
  input  logic             cs_ready,
  output logic [CS_W-1:0]  cs_state,
  output logic [SUB_W-1:0] cs_sub,
  output logic             cs_wake_masked
);

  logic            trap_hit;
  logic [CS_W-1:0] trap_code;
  logic            busy;
  logic            trap_done;

  idle_lvl_decode #(
    .AW(AW), .LW(LW), .LVL_FIRST(LVL_FIRST), .LVL_COUNT(LVL_COUNT), .LVL_OFS(2)
  ) u_decode (
    .cfg_en   (cfg_en),
    .cfg_base (cfg_base),
    .cfg_limit(cfg_limit),
    .rd_addr  (rd_addr),
    .trap_hit (trap_hit),
    .trap_code(trap_code)
  );

  idle_req_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .rd_valid      (rd_valid),
    .trap_hit      (trap_hit),
    .trap_code     (trap_code),
    .cs_ready      (cs_ready),
    .cs_valid      (cs_valid),
    .cs_state      (cs_state),
    .cs_sub        (cs_sub),
    .cs_wake_masked(cs_wake_masked),
    .busy          (busy),
    .trap_done     (trap_done)
  );

  idle_pass_mux #(.AW(AW), .DW(DW)) u_mux (
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .io_ready (io_ready),
    .trap_hit (trap_hit),
    .busy     (busy),
    .trap_done(trap_done),
    .io_valid (io_valid),
    .io_addr  (io_addr),
    .rd_ready (rd_ready),
    .cpl_valid(cpl_valid),
    .cpl_data (cpl_data)
  );

endmodule

// File: rtl/idle_io_redirect_chk.sv
module idle_io_redirect_chk #(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_valid,
  input logic [AW-1:0] rd_addr,
  input logic          rd_ready,
  input logic          cpl_valid,
  input logic [DW-1:0] cpl_data,
  input logic          io_valid,
  input logic [AW-1:0] io_addr,
  input logic          io_ready,
  input logic          cfg_en,
  input logic          cs_valid,
  input logic          cs_ready,
  input logic [3:0]    cs_state,
  input logic [3:0]    cs_sub,
  input logic          cs_wake_masked
);

  // R1: disabled and idle means a transparent path
  p_transparent_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cs_valid && !cpl_valid) |->
      (io_valid == rd_valid && io_addr == rd_addr && rd_ready == io_ready));

  // R3: only C3 or C6 is ever requested
  p_state_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_valid |-> (cs_state == 4'd3 || cs_state == 4'd6));

  // R5: no external read while a trapped read is in flight
  p_no_io_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid || cpl_valid) |-> !io_valid);

  // R6: the substate is zero
  p_sub_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_valid |-> cs_sub == 4'd0);

  // R7: wake on a masked interrupt is set
  p_wake_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_valid |-> cs_wake_masked);

  // R8: a stalled request holds and the read stays stalled
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid && !cs_ready) |=> (cs_valid && $stable(cs_state) && !rd_ready));

  // R9: completion follows acceptance with zero data
  p_cpl_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_valid && cs_ready) |=> (cpl_valid && rd_ready && cpl_data == '0));

  // R9: the completion lasts one cycle
  p_cpl_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);

endmodule

bind idle_io_redirect idle_io_redirect_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
  .rd_ready(rd_ready), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
  .io_valid(io_valid), .io_addr(io_addr), .io_ready(io_ready),
  .cfg_en(cfg_en), .cs_valid(cs_valid), .cs_ready(cs_ready),
  .cs_state(cs_state), .cs_sub(cs_sub), .cs_wake_masked(cs_wake_masked)
);

// File: tb/test_idle_io_redirect.sv
module test_idle_io_redirect;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic [15:0] rd_addr = '0;
  logic        rd_ready;
  logic        cpl_valid;
  logic [31:0] cpl_data;
  logic        io_valid;
  logic [15:0] io_addr;
  logic        io_ready = 1'b0;
  logic        cfg_en = 1'b0;
  logic [15:0] cfg_base = 16'h0400;
  logic [2:0]  cfg_limit = 3'd3;
  logic        cs_valid;
  logic        cs_ready = 1'b0;
  logic [3:0]  cs_state;
  logic [3:0]  cs_sub;
  logic        cs_wake_masked;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  idle_io_redirect i_idle_io_redirect (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
    .rd_ready(rd_ready), .cpl_valid(cpl_valid), .cpl_data(cpl_data),
    .io_valid(io_valid), .io_addr(io_addr), .io_ready(io_ready),
    .cfg_en(cfg_en), .cfg_base(cfg_base), .cfg_limit(cfg_limit),
    .cs_valid(cs_valid), .cs_ready(cs_ready), .cs_state(cs_state),
    .cs_sub(cs_sub), .cs_wake_masked(cs_wake_masked)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Forwarded read: combinational path, ready follows the I/O side.
  task automatic t_forward(input string req, input logic [15:0] a);
    rd_addr  = a;
    rd_valid = 1'b1;
    io_ready = 1'b0;
    #1;
    check({req, " io_valid"}, 32'(io_valid), 32'd1);
    check({req, " io_addr"}, 32'(io_addr), 32'(a));
    check({req, " R11 ready stalls"}, 32'(rd_ready), 32'd0);
    io_ready = 1'b1;
    #1;
    check({req, " R11 ready follows"}, 32'(rd_ready), 32'd1);
    tick();
    check({req, " no cs_valid"}, 32'(cs_valid), 32'd0);
    check({req, " no cpl_valid"}, 32'(cpl_valid), 32'd0);
    rd_valid = 1'b0;
    io_ready = 1'b0;
    tick();
  endtask

  // Trapped read with a given number of stall cycles on the request channel.
  task automatic t_trap(input logic [15:0] a, input logic [3:0] exp_state, input int stall);
    rd_addr  = a;
    rd_valid = 1'b1;
    io_ready = 1'b1;
    cs_ready = 1'b0;
    #1;
    check("R5 no io_valid on arrival", 32'(io_valid), 32'd0);
    check("R8 read held on arrival", 32'(rd_ready), 32'd0);
    tick();
    check("R8 cs_valid rises", 32'(cs_valid), 32'd1);
    check("R3 cs_state", 32'(cs_state), 32'(exp_state));
    check("R6 cs_sub zero", 32'(cs_sub), 32'd0);
    check("R7 wake flag", 32'(cs_wake_masked), 32'd1);
    check("R5 no io_valid", 32'(io_valid), 32'd0);
    for (int k = 0; k < stall; k++) begin
      tick();
      check("R8 held valid", 32'(cs_valid), 32'd1);
      check("R8 held state", 32'(cs_state), 32'(exp_state));
      check("R8 read stalled", 32'(rd_ready), 32'd0);
    end
    cs_ready = 1'b1;
    tick();
    cs_ready = 1'b0;
    check("R9 cpl_valid", 32'(cpl_valid), 32'd1);
    check("R9 rd_ready", 32'(rd_ready), 32'd1);
    check("R9 cpl_data zero", cpl_data, 32'd0);
    check("R9 cs_valid dropped", 32'(cs_valid), 32'd0);
    check("R5 no io_valid at completion", 32'(io_valid), 32'd0);
    tick();
    rd_valid = 1'b0;
    io_ready = 1'b0;
    check("R9 single pulse", 32'(cpl_valid), 32'd0);
    tick();
  endtask

  task automatic t_reset();
    check("R10 cs_valid", 32'(cs_valid), 32'd0);
    check("R10 cpl_valid", 32'(cpl_valid), 32'd0);
  endtask

  task automatic t_disabled();
    cfg_en = 1'b0;
    cfg_limit = 3'd3;
    t_forward("R1 lvl2 disabled", cfg_base + 16'd4);
    t_forward("R1 lvl3 disabled", cfg_base + 16'd5);
  endtask

  task automatic t_levels();
    cfg_en = 1'b1;
    cfg_limit = 3'd3;
    t_trap(cfg_base + 16'd4, 4'd3, 0);
    t_trap(cfg_base + 16'd5, 4'd6, 0);
    t_forward("R2 base+3 forwarded", cfg_base + 16'd3);
    t_forward("R2 base+6 forwarded", cfg_base + 16'd6);
  endtask

  task automatic t_limits();
    cfg_en = 1'b1;
    cfg_limit = 3'd2;
    t_trap(cfg_base + 16'd4, 4'd3, 0);
    t_forward("R4 lvl3 above limit", cfg_base + 16'd5);
    cfg_limit = 3'd1;
    t_forward("R4 lvl2 limit 1", cfg_base + 16'd4);
    t_forward("R4 lvl3 limit 1", cfg_base + 16'd5);
    cfg_limit = 3'd7;
    t_trap(cfg_base + 16'd5, 4'd6, 0);
  endtask

  task automatic t_stall();
    cfg_en = 1'b1;
    cfg_limit = 3'd3;
    t_trap(cfg_base + 16'd5, 4'd6, 4);
  endtask

  task automatic t_wrap();
    cfg_en = 1'b1;
    cfg_limit = 3'd3;
    cfg_base = 16'hFFFC;
    t_trap(16'h0000, 4'd3, 1);
    t_trap(16'h0001, 4'd6, 0);
    t_forward("R2 wrap other", 16'h0002);
    cfg_base = 16'h0400;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_disabled();
        t_levels();
        t_limits();
        t_stall();
        t_wrap();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule